// File: doc/BRIEF.md
# SPI Flash Erase-Program Sequencer

This block runs complete erase and page-program operations on a serial NOR flash through a single-bit SPI link in clock mode 0. The host asks for one of four erase sizes (4 KiB sector, 32 KiB block, 64 KiB block or the whole device) or for a program of 1 to 256 bytes inside one page. The block then carries out the whole operation. It sends a write-enable frame, then a frame with the operation opcode and a 24-bit address, MSB first. For a program, the data bytes follow in the same frame. It then reads the status register over and over until the device reports it is ready, and finally pulses `done`.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is accepted on a cycle where `req_valid` and `req_ready` are both high. Program data comes in on a separate valid/ready stream. `wr_ready` is high only while the block waits for the next data byte. If the host holds `wr_valid` low, the block applies back-pressure by keeping chip select asserted and SCK idle until a byte arrives, and no byte is ever dropped. A program that would cross a page boundary is refused without touching the bus. Polling gives up after a programmable number of clock cycles.

Top module: `flash_erase_prog_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `done`, `err_reject` and `err_timeout` are 0.
- R2: Every accepted operation starts with a frame that carries only the byte 0x06. Between any two frames, `spi_cs_n` stays high for at least one SCK period (2*HALF_DIV clock cycles).
- R3: The `req_op` codes 0, 1 and 2 send one frame with opcode 0x20, 0x52 or 0xD8 respectively, followed by the three address bytes, most significant byte first.
- R4: `req_op` code 3 (whole-chip erase) sends a frame holding only 0xC7, with no address bytes.
- R5: `req_op` code 4 (program) sends one frame with 0x02, the three address bytes, and then exactly `req_len` data bytes in the order they were taken from the stream.
- R6: `wr_ready` is high only while a data byte is awaited. While `wr_valid` stays low in that state, `spi_cs_n` stays low and `spi_sck` stays low.
- R7: After the operation frame, the block repeats a status frame {0x05, 0x00} until bit 0 of the byte read back is 0. It then pulses `done` for one cycle with both error flags low.
- R8: A request is rejected when `req_op` is 5, 6 or 7, or when it is a program with `req_len` = 0 or `req_addr[7:0]` + `req_len` > 256. A rejected request produces no SPI activity, and `done` and `err_reject` are high in the cycle after acceptance.
- R9: A cycle counter restarts when the operation frame ends. If a status read shows busy and the counter is at or above `timeout_limit`, polling stops and `done` is raised with `err_timeout` set.
- R10: Bytes are sent MSB first. MOSI changes only while SCK is low, and every frame holds a whole number of bytes.
- R11: `req_ready` stays low while an operation is in progress. The error flags keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 3 | 0: 4 KiB, 1: 32 KiB, 2: 64 KiB, 3: chip erase, 4: program |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 9 | Program byte count, 1 to 256 |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Block waits for a data byte |
| wr_data | input | 8 | Program data byte |
| timeout_limit | input | 24 | Polling limit in clock cycles |
| done | output | 1 | One-cycle completion pulse |
| err_reject | output | 1 | Last request was refused |
| err_timeout | output | 1 | Last operation stopped polling on timeout |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The hardest case to reach from the ports is the timeout abort. It needs a device that stays busy, and it needs the limit to expire at a known status read, so the set of expected frames is exact. The bench flash model stays busy for a configurable number of status reads. The timeout test sets that number to 50 and the limit to 0, so the abort must follow the very first busy read. A later run with a large limit and several busy reads confirms that polling finishes normally. Stream back-pressure is reached by withholding `wr_valid` on alternate cycles during a program that ends exactly on a page boundary.

// File: rtl/fepseq_pkg.sv
package fepseq_pkg;

  typedef enum logic [2:0] {
    OP_ERASE_4K  = 3'd0,
    OP_ERASE_32K = 3'd1,
    OP_ERASE_64K = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_PROGRAM   = 3'd4
  } fseq_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_GAP,
    ST_OPC,
    ST_ADDR,
    ST_DWAIT,
    ST_DSHIFT,
    ST_PCMD,
    ST_PREAD
  } fseq_state_e;

  localparam logic [7:0] CMD_WRITE_EN  = 8'h06;
  localparam logic [7:0] CMD_READ_STAT = 8'h05;
  localparam logic [7:0] CMD_FILLER    = 8'h00;

  function automatic logic [7:0] op_opcode(input logic [2:0] op);
    case (op)
      3'(OP_ERASE_4K):  return 8'h20;
      3'(OP_ERASE_32K): return 8'h52;
      3'(OP_ERASE_64K): return 8'hD8;
      3'(OP_ERASE_ALL): return 8'hC7;
      3'(OP_PROGRAM):   return 8'h02;
      default:          return 8'h00;
    endcase
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'(OP_PROGRAM);
  endfunction

endpackage

// File: rtl/fepseq_spi_shift.sv
module fepseq_spi_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic       last_bit
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             active;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      div_cnt  <= '0;
      bitn     <= '0;
      sh       <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
      last_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        sh      <= tx;
        mosi    <= tx[7];
        div_cnt <= '0;
        bitn    <= '0;
        sck     <= 1'b0;
      end else if (active) begin
        if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          if (!sck) begin
            sck      <= 1'b1;
            last_bit <= miso;
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
              mosi   <= 1'b0;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end

  assign busy = active;

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sck && !busy));

endmodule

// File: rtl/fepseq_req_chk.sv
module fepseq_req_chk
  import fepseq_pkg::*;
#(
  parameter int PG_W  = 8,
  parameter int LEN_W = PG_W + 1
) (
  input  logic [2:0]       op,
  input  logic [PG_W-1:0]  addr_lo,
  input  logic [LEN_W-1:0] len,
  output logic             bad
);
  localparam logic [LEN_W:0] PAGE = (LEN_W + 1)'(1) << PG_W;

  logic [LEN_W:0] end_pos;
  logic           prog_bad;

  always_comb begin
    end_pos  = {2'b00, addr_lo} + {1'b0, len};
    prog_bad = (len == '0) || (end_pos > PAGE);
    bad      = !op_known(op) || ((op == 3'(OP_PROGRAM)) && prog_bad);
  end

endmodule

// File: rtl/fepseq_ctrl.sv
module fepseq_ctrl
  import fepseq_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 9,
  parameter int HALF_DIV   = 2,
  parameter int TO_W       = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    req_bad,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [7:0]              wr_data,
  input  logic [TO_W-1:0]         timeout_limit,
  output logic                    sh_start,
  output logic [7:0]              sh_tx,
  input  logic                    sh_busy,
  input  logic                    sh_done,
  input  logic                    sh_last_bit,
  input  logic                    spi_sck,
  output logic                    cs_n,
  output logic                    done,
  output logic                    err_reject,
  output logic                    err_timeout
);
  localparam int ADDR_W  = 8 * ADDR_BYTES;
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GAP_W   = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int AB_W    = $clog2(ADDR_BYTES + 1);

  fseq_state_e         st, gap_nxt;
  logic [2:0]          op_q;
  logic [ADDR_W-1:0]   addr_sh;
  logic [LEN_W-1:0]    left;
  logic [AB_W-1:0]     abyte;
  logic [GAP_W-1:0]    gap_cnt;
  logic [TO_W-1:0]     poll_cnt;
  logic                polling;
  logic                to_hit;

  assign req_ready = (st == ST_IDLE);
  assign wr_ready  = (st == ST_DWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      gap_nxt     <= ST_IDLE;
      op_q        <= '0;
      addr_sh     <= '0;
      left        <= '0;
      abyte       <= '0;
      gap_cnt     <= '0;
      poll_cnt    <= '0;
      polling     <= 1'b0;
      to_hit      <= 1'b0;
      cs_n        <= 1'b1;
      sh_start    <= 1'b0;
      sh_tx       <= '0;
      done        <= 1'b0;
      err_reject  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      done     <= 1'b0;
      if (polling && (poll_cnt != '1)) poll_cnt <= poll_cnt + TO_W'(1);
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            err_reject  <= 1'b0;
            err_timeout <= 1'b0;
            if (req_bad) begin
              done       <= 1'b1;
              err_reject <= 1'b1;
            end else begin
              op_q     <= req_op;
              addr_sh  <= req_addr;
              left     <= req_len;
              to_hit   <= 1'b0;
              cs_n     <= 1'b0;
              sh_start <= 1'b1;
              sh_tx    <= CMD_WRITE_EN;
              st       <= ST_WREN;
            end
          end
        end
        ST_WREN: begin
          if (sh_done) begin
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            gap_nxt <= ST_OPC;
            st      <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            if (gap_nxt == ST_IDLE) begin
              done        <= 1'b1;
              err_timeout <= to_hit;
              polling     <= 1'b0;
              st          <= ST_IDLE;
            end else begin
              cs_n     <= 1'b0;
              sh_start <= 1'b1;
              sh_tx    <= (gap_nxt == ST_OPC) ? op_opcode(op_q) : CMD_READ_STAT;
              st       <= gap_nxt;
            end
          end else begin
            gap_cnt <= gap_cnt + GAP_W'(1);
          end
        end
        ST_OPC: begin
          if (sh_done) begin
            if (op_q == 3'(OP_ERASE_ALL)) begin
              cs_n     <= 1'b1;
              gap_cnt  <= '0;
              gap_nxt  <= ST_PCMD;
              st       <= ST_GAP;
              polling  <= 1'b1;
              poll_cnt <= '0;
            end else begin
              sh_start <= 1'b1;
              sh_tx    <= addr_sh[ADDR_W-1 -: 8];
              addr_sh  <= addr_sh << 8;
              abyte    <= '0;
              st       <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (sh_done) begin
            if (abyte == AB_W'(ADDR_BYTES - 1)) begin
              if (op_q == 3'(OP_PROGRAM)) begin
                st <= ST_DWAIT;
              end else begin
                cs_n     <= 1'b1;
                gap_cnt  <= '0;
                gap_nxt  <= ST_PCMD;
                st       <= ST_GAP;
                polling  <= 1'b1;
                poll_cnt <= '0;
              end
            end else begin
              abyte    <= abyte + AB_W'(1);
              sh_start <= 1'b1;
              sh_tx    <= addr_sh[ADDR_W-1 -: 8];
              addr_sh  <= addr_sh << 8;
            end
          end
        end
        ST_DWAIT: begin
          if (wr_valid) begin
            sh_start <= 1'b1;
            sh_tx    <= wr_data;
            st       <= ST_DSHIFT;
          end
        end
        ST_DSHIFT: begin
          if (sh_done) begin
            left <= left - LEN_W'(1);
            if (left == LEN_W'(1)) begin
              cs_n     <= 1'b1;
              gap_cnt  <= '0;
              gap_nxt  <= ST_PCMD;
              st       <= ST_GAP;
              polling  <= 1'b1;
              poll_cnt <= '0;
            end else begin
              st <= ST_DWAIT;
            end
          end
        end
        ST_PCMD: begin
          if (sh_done) begin
            sh_start <= 1'b1;
            sh_tx    <= CMD_FILLER;
            st       <= ST_PREAD;
          end
        end
        ST_PREAD: begin
          if (sh_done) begin
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            st      <= ST_GAP;
            if (!sh_last_bit) begin
              gap_nxt <= ST_IDLE;
            end else if (poll_cnt >= timeout_limit) begin
              to_hit  <= 1'b1;
              gap_nxt <= ST_IDLE;
            end else begin
              gap_nxt <= ST_PCMD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  // R8
  reject_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bad) |=> (done && err_reject && cs_n));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !spi_sck));

  // R9
  to_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> done);

  // R6
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> (!cs_n && !spi_sck));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !sh_busy);

endmodule

// File: rtl/flash_erase_prog_seq.sv
module flash_erase_prog_seq #(
  parameter int ADDR_BYTES = 3,
  parameter int PAGE_BYTES = 256,
  parameter int HALF_DIV   = 2,
  parameter int TO_W       = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [2:0]                    req_op,
  input  logic [8*ADDR_BYTES-1:0]       req_addr,
  input  logic [$clog2(PAGE_BYTES):0]   req_len,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [7:0]                    wr_data,
  input  logic [TO_W-1:0]               timeout_limit,
  output logic                          done,
  output logic                          err_reject,
  output logic                          err_timeout,
  output logic                          spi_sck,
  output logic                          spi_cs_n,
  output logic                          spi_mosi,
  input  logic                          spi_miso
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int LEN_W = PG_W + 1;

  logic       req_bad;
  logic       sh_start, sh_busy, sh_done, sh_last_bit;
  logic [7:0] sh_tx;

  fepseq_req_chk #(.PG_W(PG_W), .LEN_W(LEN_W)) u_chk (
    .op      (req_op),
    .addr_lo (req_addr[PG_W-1:0]),
    .len     (req_len),
    .bad     (req_bad)
  );

  fepseq_ctrl #(
    .ADDR_BYTES (ADDR_BYTES),
    .LEN_W      (LEN_W),
    .HALF_DIV   (HALF_DIV),
    .TO_W       (TO_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .req_bad       (req_bad),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_data       (wr_data),
    .timeout_limit (timeout_limit),
    .sh_start      (sh_start),
    .sh_tx         (sh_tx),
    .sh_busy       (sh_busy),
    .sh_done       (sh_done),
    .sh_last_bit   (sh_last_bit),
    .spi_sck       (spi_sck),
    .cs_n          (spi_cs_n),
    .done          (done),
    .err_reject    (err_reject),
    .err_timeout   (err_timeout)
  );

  fepseq_spi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sh_start),
    .tx       (sh_tx),
    .miso     (spi_miso),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .busy     (sh_busy),
    .done     (sh_done),
    .last_bit (sh_last_bit)
  );

endmodule

// File: tb/sim_flash_erase_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_prog_seq;
  localparam int HALF_DIV = 2;
  localparam realtime CYC = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [8:0]  req_len = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic [23:0] timeout_limit = '0;
  logic        done, err_reject, err_timeout;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #(CYC/2) clk = ~clk;

  flash_erase_prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .timeout_limit(timeout_limit), .done(done), .err_reject(err_reject),
    .err_timeout(err_timeout), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;
  int    exp_q[$];
  string tag_q[$];
  int    wq[$];
  bit    stall_mode = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // ---------------- flash model and scoreboard monitor ----------------
  logic [7:0] m_sh = '0;
  logic [7:0] m_cmd = '0;
  int m_bits = 0, m_idx = 0;
  int busy_polls = 0, busy_cfg = 0;
  logic p_sck = 1'b0, p_cs = 1'b1;
  realtime t_rise = 0;
  bit seen_frame = 1'b0;

  assign spi_miso = (!spi_cs_n && m_cmd == 8'h05 && m_idx == 1 && m_bits == 7)
                    ? (busy_polls > 0) : 1'b0;

  task automatic got_byte(input int b);
    string t;
    t = (tag_q.size() > 0) ? tag_q[0] : "R10";
    if (exp_q.size() == 0 || exp_q[0] < 0) begin
      chk(1'b0, t, "unexpected SPI byte", b, -1);
    end else begin
      chk(exp_q[0] == b, t, "SPI byte", b, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  endtask

  task automatic frame_end();
    chk(m_bits == 0, "R10", "whole bytes in frame", m_bits, 0);
    if (exp_q.size() == 0 || exp_q[0] != -1) begin
      chk(1'b0, "R2", "frame end position", m_idx, -1);
    end else begin
      chk(1'b1, "R2", "frame end", 0, 0);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (m_idx > 0 && m_cmd == 8'h05) begin
      if (busy_polls > 0) busy_polls--;
    end else if (m_idx > 0 && m_cmd != 8'h06) begin
      busy_polls = busy_cfg;
    end
  endtask

  initial forever begin
    @(spi_sck or spi_cs_n);
    if (spi_cs_n && !p_cs) begin
      frame_end();
      t_rise = $realtime;
      seen_frame = 1'b1;
    end else if (!spi_cs_n && p_cs) begin
      if (seen_frame)
        chk(($realtime - t_rise) >= 2*HALF_DIV*CYC, "R2", "CS high gap (ps)",
            int'(($realtime - t_rise)/1ps), int'(2*HALF_DIV*CYC/1ps));
      m_bits = 0; m_idx = 0; m_cmd = '0;
    end else if (spi_sck && !p_sck) begin
      if (spi_cs_n) chk(1'b0, "R10", "SCK pulse with CS high", 1, 0);
      else begin
        m_sh = {m_sh[6:0], spi_mosi};
        m_bits++;
        if (m_bits == 8) begin
          if (m_idx == 0) m_cmd = m_sh;
          got_byte(int'(m_sh));
          m_idx++;
          m_bits = 0;
        end
      end
    end
    p_sck = spi_sck;
    p_cs  = spi_cs_n;
  end

  // ---------------- program data stream driver ----------------
  initial begin
    bit pend = 1'b0;
    bit odd = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) void'(wq.pop_front());
      odd = !odd;
      wr_valid = (wq.size() > 0) && !(stall_mode && odd);
      wr_data  = (wq.size() > 0) ? 8'(wq[0]) : 8'h00;
      pend     = wr_valid && wr_ready;
    end
  end

  // ---------------- expected-item driver ----------------
  function automatic int opc(input logic [2:0] op);
    case (op)
      3'd0: return 'h20;
      3'd1: return 'h52;
      3'd2: return 'hD8;
      3'd3: return 'hC7;
      default: return 'h02;
    endcase
  endfunction

  task automatic push(input int b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic do_op(input logic [2:0] op, input logic [23:0] addr, input int len,
                       input int busy, input int limit, input int n_poll,
                       input bit exp_rej, input bit exp_to, input int seed,
                       input string tag);
    int cyc;
    if (!exp_rej) begin
      push('h06, "R2"); push(-1, "R2");
      push(opc(op), tag);
      if (op != 3'd3) begin
        push(int'(addr[23:16]), tag);
        push(int'(addr[15:8]), tag);
        push(int'(addr[7:0]), tag);
      end
      if (op == 3'd4) begin
        for (int i = 0; i < len; i++) begin
          int d;
          d = (i * 7 + seed) & 255;
          wq.push_back(d);
          push(d, "R5");
        end
      end
      push(-1, tag);
      for (int i = 0; i < n_poll; i++) begin
        push('h05, "R7"); push('h00, "R7"); push(-1, "R7");
      end
    end
    busy_cfg = busy;
    timeout_limit = 24'(limit);
    @(negedge clk);
    req_op = op; req_addr = addr; req_len = 9'(len); req_valid = 1'b1;
    chk(req_ready == 1'b1, "R11", "req_ready idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_rej) begin
      chk(done == 1'b1, "R8", "done right after reject", done, 1);
      chk(spi_cs_n == 1'b1, "R8", "CS stays high on reject", spi_cs_n, 1);
    end else begin
      chk(req_ready == 1'b0, "R11", "req_ready low while busy", req_ready, 0);
    end
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, tag, "done seen", done, 1);
    chk(err_reject == exp_rej, exp_rej ? "R8" : "R7", "err_reject", err_reject, exp_rej);
    chk(err_timeout == exp_to, "R9", "err_timeout", err_timeout, exp_to);
    chk(exp_q.size() == 0, tag, "scoreboard drained", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done is one pulse", done, 0);
    exp_q.delete(); tag_q.delete(); wq.delete();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(err_reject == 1'b0 && err_timeout == 1'b0, "R1", "flags after reset",
        {err_reject, err_timeout}, 0);

    // R3 erase sizes
    do_op(3'd0, 24'h123456, 0, 2, 100000, 3, 1'b0, 1'b0, 0, "R3");
    do_op(3'd1, 24'h7F8000, 0, 0, 100000, 1, 1'b0, 1'b0, 0, "R3");
    do_op(3'd2, 24'hABCDEF, 0, 1, 100000, 2, 1'b0, 1'b0, 0, "R3");
    // R4 whole chip
    do_op(3'd3, 24'h555555, 0, 3, 100000, 4, 1'b0, 1'b0, 0, "R4");
    // R5 small program
    do_op(3'd4, 24'h000100, 4, 1, 100000, 2, 1'b0, 1'b0, 3, "R5");
    // R6 back-pressure, ends exactly on the page boundary
    stall_mode = 1'b1;
    do_op(3'd4, 24'h0012F0, 16, 0, 100000, 1, 1'b0, 1'b0, 11, "R6");
    stall_mode = 1'b0;
    // R5 full page
    do_op(3'd4, 24'h345600, 256, 1, 100000, 2, 1'b0, 1'b0, 5, "R5");
    // R8 rejections
    do_op(3'd4, 24'h0012F1, 16, 0, 100000, 0, 1'b1, 1'b0, 0, "R8");
    do_op(3'd4, 24'h001200, 0, 0, 100000, 0, 1'b1, 1'b0, 0, "R8");
    do_op(3'd6, 24'h000000, 1, 0, 100000, 0, 1'b1, 1'b0, 0, "R8");
    // R9 timeout at first busy read
    do_op(3'd0, 24'h00A000, 0, 50, 0, 1, 1'b0, 1'b1, 0, "R9");
    busy_polls = 0;
    repeat (10) @(negedge clk);
    chk(err_timeout == 1'b1, "R11", "err_timeout held", err_timeout, 1);
    // R9 large limit: polling ends normally and clears the flag
    do_op(3'd2, 24'h010000, 0, 4, 100000, 5, 1'b0, 1'b0, 0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule